// File: doc/BRIEF.md
# Precise Exception Tracker

This block follows the exception state of every instruction in a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each stage slot holds a valid bit, a bubble marker, the instruction's PC and a cause code. Faults may be raised by any of the first four stages, and in any order in time. The cause stays attached to its instruction and moves down with it. Nothing is acted upon before the instruction sits in writeback. There the faulting PC and its cause are latched, fetch is steered to the handler address, and every younger instruction in flight is wiped.

External interrupt requests do not stop fetch directly. The block puts a marked bubble into the fetch slot in place of an instruction. That bubble is treated as an exception once it reaches writeback. Surrounding logic supplies per-stage fault strobes and uses the write-enable outputs to gate architectural updates. The reset input is expected to have been synchronised upstream, so its release lines up with the clock.

Top module: `exc_tracker`

## Requirements
- R1: While reset is asserted, the fetch PC equals RESET_PC, and exc_take, commit_valid, mem_we, epc and ecause are all zero.
- R2: With no fault and no interrupt, the fetch PC advances by 4 each cycle from RESET_PC, and instructions commit in fetch order. commit_pc equals the PC fetched four cycles earlier, and mem_we is high for a clean instruction in the memory stage.
- R3: A fault strobe applies to the instruction that currently occupies its stage, and each strobe gives its own cause code: itlb_fault in fetch gives 1, idec_fault in decode gives 2, alu_ovf in execute gives 3, dtlb_fault in memory gives 4. exc_take rises only when that instruction is in writeback, which is four cycles after it was fetched.
- R4: In the cycle after exc_take, epc holds the PC of the faulting instruction and ecause holds its code. Every older instruction has committed by then, so the number of commits before exc_take equals (epc − RESET_PC)/4.
- R5: In the cycle after exc_take, fetch_pc equals VECTOR_PC. The instruction fetched there commits five cycles after exc_take.
- R6: In the exc_take cycle mem_we is low. During the four cycles that follow, commit_valid stays low, because all younger instructions have become no-ops.
- R7: When a younger instruction is flagged earlier in time than an older one, the older instruction's exception is the one taken.
- R8: When one instruction is flagged by two stages, the cause recorded first (the earlier stage) is kept.
- R9: An instruction carrying a cause never raises commit_valid. mem_we is low while the memory-stage instruction carries a cause.
- R10: An interrupt request (irq_req high) puts a bubble with cause 5 into fetch. The bubble carries the current fetch PC, and the fetch PC does not advance in that cycle, so epc names the instruction to resume.
- R11: If the interrupt bubble is flushed by an older exception while irq_req stays high, a new bubble is injected at the handler address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| irq_req | input | 1 | Level external interrupt request |
| itlb_fault | input | 1 | Fetch-stage translation fault for the instruction being fetched |
| idec_fault | input | 1 | Decode-stage illegal opcode |
| alu_ovf | input | 1 | Execute-stage arithmetic overflow |
| dtlb_fault | input | 1 | Memory-stage translation fault |
| fetch_pc | output | 32 | PC being fetched this cycle |
| mem_we | output | 1 | Memory-stage write permitted |
| commit_valid | output | 1 | Writeback instruction may update registers |
| commit_pc | output | 32 | PC of the instruction in writeback |
| exc_take | output | 1 | Exception being taken in writeback this cycle |
| epc | output | 32 | Latched PC of the last taken exception |
| ecause | output | 3 | Latched cause code of the last taken exception |

## Verification
The bench builds the tracker with RESET_PC at 0 and VECTOR_PC at 0x200. With these values every sequential PC is exactly four times the cycle count since reset, so the bench can work out each expected EPC and take cycle by hand. The handler address lies well clear of the sequential range, so a redirect cannot be mistaken for ordinary sequencing. The same values also make the reinjected interrupt bubble visible as an EPC equal to the handler address.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  localparam int PC_W = 32;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_ITLB = 3'd1,
    CAUSE_ILL  = 3'd2,
    CAUSE_OVF  = 3'd3,
    CAUSE_DTLB = 3'd4,
    CAUSE_IRQ  = 3'd5
  } cause_e;

  typedef struct packed {
    logic            valid;
    logic            bubble;
    logic [PC_W-1:0] pc;
    cause_e          cause;
  } slot_t;

  // stage index 0=decode, 1=execute, 2=memory, 3=writeback
  function automatic cause_e stage_cause(input int idx);
    case (idx)
      0:       return CAUSE_ILL;
      1:       return CAUSE_OVF;
      2:       return CAUSE_DTLB;
      default: return CAUSE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/exc_fetch.sv
`timescale 1ns/1ps
module exc_fetch
  import exc_pkg::*;
#(
  parameter logic [PC_W-1:0] RESET_PC  = '0,
  parameter logic [PC_W-1:0] VECTOR_PC = 32'h0000_0080,
  parameter int              PC_STEP   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_req,
  input  logic            itlb_fault,
  input  logic            redirect,
  output logic [PC_W-1:0] pc_o,
  output slot_t           slot_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  logic [PC_W-1:0] pc_q, pc_d;
  logic            inflight_q, inflight_d;
  logic            inject;

  always_comb begin
    inject     = irq_req && !inflight_q;
    pc_d       = pc_q;
    inflight_d = inflight_q;
    if (redirect) begin
      pc_d       = VECTOR_PC;
      inflight_d = 1'b0;
    end else if (inject) begin
      inflight_d = 1'b1;
    end else begin
      pc_d = pc_q + STEP;
    end
  end

  always_comb begin
    slot_o.valid  = 1'b1;
    slot_o.bubble = inject;
    slot_o.pc     = pc_q;
    if (inject)          slot_o.cause = CAUSE_IRQ;
    else if (itlb_fault) slot_o.cause = CAUSE_ITLB;
    else                 slot_o.cause = CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q       <= RESET_PC;
      inflight_q <= 1'b0;
    end else begin
      pc_q       <= pc_d;
      inflight_q <= inflight_d;
    end
  end

  assign pc_o = pc_q;

  // R5: handler address is fetched the cycle after a commit-time redirect
  a_r5_vector_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (pc_o == VECTOR_PC));

  // R10: fetch PC is held while an interrupt bubble takes the fetch slot
  a_r10_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_o.bubble && !redirect) |=> (pc_o == $past(pc_o)));
endmodule

// File: rtl/exc_stage.sv
`timescale 1ns/1ps
module exc_stage
  import exc_pkg::*;
#(
  parameter cause_e OWN_CAUSE = CAUSE_NONE
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flush,
  input  logic  fault,
  input  slot_t slot_i,
  output slot_t slot_o
);
  slot_t held_q, held_d;
  logic  tag_new;

  always_comb begin
    held_d = flush ? '0 : slot_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  // a cause already carried is never replaced (first one in program order wins)
  always_comb begin
    tag_new = (OWN_CAUSE != CAUSE_NONE) && fault && held_q.valid &&
              !held_q.bubble && (held_q.cause == CAUSE_NONE);
    slot_o  = held_q;
    if (tag_new) slot_o.cause = OWN_CAUSE;
  end

  // R6: a flush leaves this stage empty on the next cycle
  a_r6_stage_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !slot_o.valid);
endmodule

// File: rtl/exc_commit.sv
`timescale 1ns/1ps
module exc_commit
  import exc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  slot_t           wb_i,
  output logic            take_o,
  output logic            commit_o,
  output logic [PC_W-1:0] epc_o,
  output logic [2:0]      cause_o
);
  logic [PC_W-1:0] epc_q, epc_d;
  cause_e          cause_q, cause_d;
  logic            cap_en;

  always_comb begin
    take_o   = wb_i.valid && (wb_i.cause != CAUSE_NONE);
    commit_o = wb_i.valid && !wb_i.bubble && (wb_i.cause == CAUSE_NONE);
    cap_en   = take_o;
    epc_d    = epc_q;
    cause_d  = cause_q;
    if (cap_en) begin
      epc_d   = wb_i.pc;
      cause_d = wb_i.cause;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= CAUSE_NONE;
    end else begin
      epc_q   <= epc_d;
      cause_q <= cause_d;
    end
  end

  assign epc_o   = epc_q;
  assign cause_o = cause_q;

  // R4: the latched PC is the one that sat in writeback when taken
  a_r4_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (epc_o == $past(wb_i.pc)));
endmodule

// File: rtl/exc_tracker.sv
`timescale 1ns/1ps
module exc_tracker
  import exc_pkg::*;
#(
  parameter logic [31:0] RESET_PC  = 32'h0000_0000,
  parameter logic [31:0] VECTOR_PC = 32'h0000_0080,
  parameter int          PC_STEP   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_req,
  input  logic        itlb_fault,
  input  logic        idec_fault,
  input  logic        alu_ovf,
  input  logic        dtlb_fault,
  output logic [31:0] fetch_pc,
  output logic        mem_we,
  output logic        commit_valid,
  output logic [31:0] commit_pc,
  output logic        exc_take,
  output logic [31:0] epc,
  output logic [2:0]  ecause
);
  localparam int ST_N   = 4;  // decode, execute, memory, writeback
  localparam int MEM_IX = 2;

  slot_t             chain [ST_N+1];
  logic [ST_N-1:0]   st_fault;

  assign st_fault = {1'b0, dtlb_fault, alu_ovf, idec_fault};

  exc_fetch #(
    .RESET_PC (RESET_PC),
    .VECTOR_PC(VECTOR_PC),
    .PC_STEP  (PC_STEP)
  ) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .itlb_fault(itlb_fault),
    .redirect  (exc_take),
    .pc_o      (fetch_pc),
    .slot_o    (chain[0])
  );

  for (genvar g = 0; g < ST_N; g++) begin : g_stage
    exc_stage #(
      .OWN_CAUSE(stage_cause(g))
    ) u_st (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (exc_take),
      .fault (st_fault[g]),
      .slot_i(chain[g]),
      .slot_o(chain[g+1])
    );
  end

  exc_commit u_commit (
    .clk     (clk),
    .rst_n   (rst_n),
    .wb_i    (chain[ST_N]),
    .take_o  (exc_take),
    .commit_o(commit_valid),
    .epc_o   (epc),
    .cause_o (ecause)
  );

  always_comb begin
    mem_we = chain[MEM_IX+1].valid && !chain[MEM_IX+1].bubble &&
             (chain[MEM_IX+1].cause == CAUSE_NONE) && !exc_take;
  end

  assign commit_pc = chain[ST_N].pc;

  // R6: nothing commits on the cycle after an exception is taken
  a_r6_drain: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> !commit_valid);
endmodule

// File: tb/sim_exc_tracker.sv
`timescale 1ns/1ps
module sim_exc_tracker;
  localparam logic [31:0] VEC = 32'h0000_0200;
  localparam int NONE = 15;

  typedef struct packed {
    logic [3:0]  f_if, f_id, f_ex, f_mem, f_irq, take;
    logic [31:0] epc;
    logic [2:0]  cause;
  } vec_t;

  // fault cycles counted from the first cycle after reset; 15 = unused
  localparam vec_t VECS [8] = '{
    '{4'd2,  4'd15, 4'd15, 4'd15, 4'd15, 4'd6, 32'd8,  3'd1}, // R3 fetch
    '{4'd15, 4'd3,  4'd15, 4'd15, 4'd15, 4'd6, 32'd8,  3'd2}, // R3 decode
    '{4'd15, 4'd15, 4'd5,  4'd15, 4'd15, 4'd7, 32'd12, 3'd3}, // R3 execute
    '{4'd15, 4'd15, 4'd15, 4'd6,  4'd15, 4'd7, 32'd12, 3'd4}, // R3 memory
    '{4'd3,  4'd15, 4'd15, 4'd5,  4'd15, 4'd6, 32'd8,  3'd4}, // R7 older wins
    '{4'd15, 4'd3,  4'd4,  4'd15, 4'd15, 4'd6, 32'd8,  3'd2}, // R8 first kept
    '{4'd15, 4'd15, 4'd15, 4'd15, 4'd2,  4'd6, 32'd8,  3'd5}, // R10 interrupt
    '{4'd1,  4'd15, 4'd4,  4'd15, 4'd15, 4'd5, 32'd4,  3'd1}  // R7 older wins
  };

  logic clk, rst_n, irq_req, itlb_fault, idec_fault, alu_ovf, dtlb_fault;
  logic [31:0] fetch_pc, commit_pc, epc;
  logic mem_we, commit_valid, exc_take;
  logic [2:0] ecause;
  int n_chk, n_bad;
  bit finished;

  exc_tracker #(.RESET_PC(32'h0), .VECTOR_PC(VEC), .PC_STEP(4)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .itlb_fault(itlb_fault),
    .idec_fault(idec_fault), .alu_ovf(alu_ovf), .dtlb_fault(dtlb_fault),
    .fetch_pc(fetch_pc), .mem_we(mem_we), .commit_valid(commit_valid),
    .commit_pc(commit_pc), .exc_take(exc_take), .epc(epc), .ecause(ecause)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    irq_req = 0; itlb_fault = 0; idec_fault = 0; alu_ovf = 0; dtlb_fault = 0;
  endtask

  task automatic do_reset();
    quiet();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic run_vec(input vec_t v);
    int ncommit;
    bit taken, order_ok, drain_ok;
    ncommit = 0; taken = 0; order_ok = 1; drain_ok = 1;
    do_reset();
    for (int k = 0; k < 13; k++) begin
      itlb_fault = (int'(v.f_if) == k);
      idec_fault = (int'(v.f_id) == k);
      alu_ovf    = (int'(v.f_ex) == k);
      dtlb_fault = (int'(v.f_mem) == k);
      irq_req    = (int'(v.f_irq) != NONE) && (k >= int'(v.f_irq)) && !taken;
      #1;
      if (k < int'(v.take)) begin
        if (exc_take) begin
          chk(0, "R3 early take", k, v.take);
        end
        if (commit_valid) begin
          if (commit_pc != 32'(4 * ncommit)) order_ok = 0;
          ncommit++;
        end
      end
      if (k == 3) chk(mem_we == 1'b1, "R2 mem_we clean", mem_we, 1);
      if (k == int'(v.f_mem)) chk(mem_we == 1'b0, "R9 mem_we faulting", mem_we, 0);
      if (k == int'(v.take)) begin
        chk(exc_take == 1'b1, "R3 take cycle", exc_take, 1);
        chk(mem_we == 1'b0, "R6 mem_we at take", mem_we, 0);
        chk(commit_valid == 1'b0, "R9 no commit of faulting", commit_valid, 0);
        chk(ncommit == int'(v.epc) / 4, "R4 older committed", ncommit, v.epc / 4);
        chk(order_ok, "R2 commit order", order_ok, 1);
      end
      if (k == int'(v.take) + 1) begin
        chk(epc == v.epc, "R4 epc", epc, v.epc);
        chk(ecause == v.cause, "R4 ecause", ecause, v.cause);
        chk(fetch_pc == VEC, "R5 redirect", fetch_pc, VEC);
      end
      if (k > int'(v.take) && k <= int'(v.take) + 4 && commit_valid) drain_ok = 0;
      if (k == int'(v.take) + 5) begin
        chk(drain_ok, "R6 younger flushed", drain_ok, 1);
        chk(commit_valid && commit_pc == VEC, "R5 handler commit", commit_pc, VEC);
      end
      if (exc_take) taken = 1;
      @(posedge clk); #1;
    end
    quiet();
  endtask

  initial begin : watchdog
    #200000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; finished = 0;
    quiet();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(fetch_pc == 32'h0, "R1 fetch_pc", fetch_pc, 0);
    chk(!exc_take && !commit_valid && !mem_we, "R1 strobes", {exc_take, commit_valid, mem_we}, 0);
    chk(epc == 0 && ecause == 0, "R1 epc/ecause", epc, 0);

    for (int i = 0; i < 8; i++) run_vec(VECS[i]);

    // R11: bubble flushed by older overflow, then reinjected at the handler
    do_reset();
    for (int k = 0; k < 13; k++) begin
      irq_req = (k >= 4);
      alu_ovf = (k == 4);
      #1;
      if (k == 6) chk(exc_take == 1'b1, "R11 first take", exc_take, 1);
      if (k == 7) begin
        chk(ecause == 3'd3 && epc == 32'd8, "R11 overflow wins", {epc, ecause}, {32'd8, 3'd3});
        chk(fetch_pc == VEC, "R11 redirect", fetch_pc, VEC);
      end
      if (k == 8) chk(fetch_pc == VEC, "R10 pc held on inject", fetch_pc, VEC);
      if (k == 11) chk(exc_take == 1'b1, "R11 second take", exc_take, 1);
      if (k == 12) begin
        chk(ecause == 3'd5, "R11 reinjected cause", ecause, 5);
        chk(epc == VEC, "R11 reinjected epc", epc, VEC);
        irq_req = 0;
      end
      @(posedge clk); #1;
    end
    quiet();

    // R1: asynchronous reset mid-run clears the latched state
    #1 rst_n = 0;
    #1;
    chk(fetch_pc == 32'h0 && epc == 0 && ecause == 0, "R1 async reset", epc, 0);
    @(posedge clk); #1 rst_n = 1;

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule